// File: doc/BRIEF.md
# Timer Channel Event Flag Register

This block keeps one sticky event flag for each timer channel and turns those flags into interrupt requests. A flag is set by a capture or compare event on its channel. Channel 0 can also be set by a wide pulse-accumulator event, and the low channels can be set by their narrow pulse-accumulator events. The counter, the capture latches and the accumulators are outside this block; their events arrive here as single-cycle pulses.

Software reads the flags through a simple register port and clears them in one of two ways. In normal mode it writes a one to each bit it wants cleared. In fast-clear mode, writes have no effect on the flags, and any read or write of a channel's data register clears that channel's flag. Capture and compare events can be held back by a programmable number of cycles before they set a flag. In pair mode, a channel marked as overwrite-protected raises its flag only on every second capture. Each flag is masked by its own interrupt enable, and a single combined request is the OR of the masked flags.

Top module: `tmr_event_flags`

## Requirements
- R1: After reset, every flag, every interrupt output and the read data are zero.
- R2: While `bus_sel` and `bus_rd` are both high, `bus_rdata` shows the current flags, with bit x holding channel x. At all other times it is zero.
- R3: With `fast_clr_en` low, a write (`bus_sel` and `bus_wr` high) clears each flag whose `bus_wdata` bit is 1 at the next edge. Flags whose bit is 0 do not change.
- R4: With `fast_clr_en` high, a register write clears no flag.
- R5: With `fast_clr_en` high, a pulse on `data_acc[x]` clears flag x only. With `fast_clr_en` low, `data_acc` has no effect.
- R6: With `dly_cycles` at 0 and pair mode off, a pulse on `cc_evt[x]` sets flag x at the next clock edge.
- R7: A pulse on `pacc16_evt` sets flag 0. A pulse on `pacc8_evt[j]` sets flag j, for j below NUM_PA8. Neither source is delayed.
- R8: When `dly_cycles` is D > 0, a `cc_evt[x]` pulse sets flag x exactly D cycles later than it would with D = 0.
- R9: A new `cc_evt[x]` pulse that arrives while a delay is pending on channel x restarts the full delay. The earlier event then never sets the flag.
- R10: When `pair_mode` is high and `ovw_prot[x]` is high, flag x is set on every second capture event of channel x. Channels whose `ovw_prot` bit is low set their flag on every event.
- R11: If a set event and a clear request reach the same flag in the same cycle, the flag ends up set.
- R12: `irq_ch[x]` is flag x AND `irq_en[x]`. `irq` is high when any bit of `irq_ch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NUM_CH | Write data; a 1 marks a flag to clear |
| bus_rdata | output | NUM_CH | Flag read data |
| fast_clr_en | input | 1 | 1 selects clear-on-data-access mode |
| data_acc | input | NUM_CH | Per-channel data register access strobes |
| cc_evt | input | NUM_CH | Capture/compare event pulses |
| pacc16_evt | input | 1 | Wide pulse-accumulator event (channel 0) |
| pacc8_evt | input | NUM_PA8 | Narrow pulse-accumulator events (low channels) |
| dly_cycles | input | DLY_W | Event delay in cycles; 0 disables the delay |
| pair_mode | input | 1 | Global two-capture mode enable |
| ovw_prot | input | NUM_CH | Per-channel overwrite-protect setting |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| irq_ch | output | NUM_CH | Masked per-channel interrupt requests |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle the effects that depend only on the current cycle:
- a pending set always produces a flag (R11);
- a normal-mode write clears its bits;
- fast mode blocks writes;
- a flag holds its value when no set or clear reaches it;
- interrupt masking and the accumulator set path behave as required.

Behaviours that span many cycles can only be shown by the bench's scenarios:
- the exact delay length for each setting;
- the restart of a pending delay;
- the every-second-capture count in pair mode.

// File: rtl/tef_pkg.sv
package tef_pkg;
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } pair_ph_e;

   typedef enum logic {
      CLR_BY_WRITE  = 1'b0,
      CLR_BY_ACCESS = 1'b1
   } clr_mode_e;
endpackage

// File: rtl/tef_delay_line.sv
module tef_delay_line #(
   parameter int NUM_CH    = 8,
   parameter int DLY_W     = 8,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DLY_W-1:0]  dly_cycles,
   input  logic [NUM_CH-1:0] evt_in,
   output logic [NUM_CH-1:0] evt_out
);
   localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
   localparam logic [DLY_W-1:0] CNT_ZERO = '0;

   if (USE_DELAY) begin : g_delay
      logic dly_off;
      assign dly_off = (dly_cycles == CNT_ZERO);

      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [DLY_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= CNT_ZERO;
            end else if (dly_off) begin
               cnt_q <= CNT_ZERO;
            end else if (evt_in[ch]) begin
               cnt_q <= dly_cycles;
            end else if (cnt_q != CNT_ZERO) begin
               cnt_q <= cnt_q - CNT_ONE;
            end
         end

         assign evt_out[ch] = dly_off ? evt_in[ch]
                                      : ((cnt_q == CNT_ONE) && !evt_in[ch]);
      end
   end else begin : g_bypass
      logic [DLY_W-1:0] unused_dly;
      logic             unused_clk;
      assign unused_dly = dly_cycles;
      assign unused_clk = clk ^ rst_n;
      assign evt_out    = evt_in;
   end
endmodule

// File: rtl/tef_pair_gate.sv
module tef_pair_gate
   import tef_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_mode,
   input  logic [NUM_CH-1:0] ovw_prot,
   input  logic [NUM_CH-1:0] evt_in,
   output logic [NUM_CH-1:0] evt_out
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pair_ph_e ph_q;
      logic     active;

      assign active = pair_mode && ovw_prot[ch];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph_q <= PH_FIRST;
         end else if (!active) begin
            ph_q <= PH_FIRST;
         end else if (evt_in[ch]) begin
            ph_q <= (ph_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
         end
      end

      assign evt_out[ch] = evt_in[ch] && (!active || (ph_q == PH_SECOND));
   end
endmodule

// File: rtl/tef_flag_bank.sv
module tef_flag_bank #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] clr_vec,
   output logic [NUM_CH-1:0] flag_q
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[ch] <= 1'b0;
         end else if (set_vec[ch]) begin
            flag_q[ch] <= 1'b1;
         end else if (clr_vec[ch]) begin
            flag_q[ch] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr_event_flags.sv
module tmr_event_flags
   import tef_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int NUM_PA8   = 4,
   parameter int DLY_W     = 8,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [NUM_CH-1:0]  bus_wdata,
   output logic [NUM_CH-1:0]  bus_rdata,
   input  logic               fast_clr_en,
   input  logic [NUM_CH-1:0]  data_acc,
   input  logic [NUM_CH-1:0]  cc_evt,
   input  logic               pacc16_evt,
   input  logic [NUM_PA8-1:0] pacc8_evt,
   input  logic [DLY_W-1:0]   dly_cycles,
   input  logic               pair_mode,
   input  logic [NUM_CH-1:0]  ovw_prot,
   input  logic [NUM_CH-1:0]  irq_en,
   output logic [NUM_CH-1:0]  irq_ch,
   output logic               irq
);
   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("tmr_event_flags: NUM_CH must be in 1..32");
   end
   if (NUM_PA8 < 1 || NUM_PA8 > NUM_CH) begin : g_bad_pa8
      $error("tmr_event_flags: NUM_PA8 must be in 1..NUM_CH");
   end
   if (DLY_W < 2) begin : g_bad_dly
      $error("tmr_event_flags: DLY_W must be at least 2");
   end

   localparam logic [NUM_CH-1:0] CH0_MASK = NUM_CH'(1);

   logic [NUM_CH-1:0] dly_evt;
   logic [NUM_CH-1:0] cc_set;
   logic [NUM_CH-1:0] pa_set;
   logic [NUM_CH-1:0] set_vec;
   logic [NUM_CH-1:0] clr_vec;
   logic [NUM_CH-1:0] flag_q;
   logic              wr_hit;
   clr_mode_e         clr_mode;

   tef_delay_line #(
      .NUM_CH   (NUM_CH),
      .DLY_W    (DLY_W),
      .USE_DELAY(USE_DELAY)
   ) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .dly_cycles(dly_cycles),
      .evt_in    (cc_evt),
      .evt_out   (dly_evt)
   );

   tef_pair_gate #(
      .NUM_CH(NUM_CH)
   ) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .pair_mode(pair_mode),
      .ovw_prot (ovw_prot),
      .evt_in   (dly_evt),
      .evt_out  (cc_set)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pa
      if (ch < NUM_PA8) begin : g_has8
         assign pa_set[ch] = pacc8_evt[ch];
      end else begin : g_no8
         assign pa_set[ch] = 1'b0;
      end
   end

   assign set_vec  = cc_set | pa_set | (pacc16_evt ? CH0_MASK : '0);
   assign clr_mode = fast_clr_en ? CLR_BY_ACCESS : CLR_BY_WRITE;
   assign wr_hit   = bus_sel && bus_wr;

   always_comb begin
      unique case (clr_mode)
         CLR_BY_ACCESS: clr_vec = data_acc;
         default:       clr_vec = wr_hit ? bus_wdata : '0;
      endcase
   end

   tef_flag_bank #(
      .NUM_CH(NUM_CH)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .flag_q (flag_q)
   );

   assign bus_rdata = (bus_sel && bus_rd) ? flag_q : '0;
   assign irq_ch    = flag_q & irq_en;
   assign irq       = |irq_ch;
endmodule

// File: rtl/tmr_event_flags_chk.sv
module tmr_event_flags_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [NUM_CH-1:0] bus_wdata,
   input logic              fast_clr_en,
   input logic [NUM_CH-1:0] data_acc,
   input logic              pacc16_evt,
   input logic [NUM_CH-1:0] irq_en,
   input logic [NUM_CH-1:0] irq_ch,
   input logic              irq,
   input logic [NUM_CH-1:0] set_vec,
   input logic [NUM_CH-1:0] flag_q
);
   logic wr_now;
   assign wr_now = bus_sel && bus_wr;

   AST_PACC16_SETS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
      pacc16_evt |=> flag_q[0]); // R7

   AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ch != '0) |-> irq); // R12

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[ch] |=> flag_q[ch]); // R11

      AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_now && !fast_clr_en && bus_wdata[ch] && !set_vec[ch]) |=> !flag_q[ch]); // R3

      AST_FAST_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_now && fast_clr_en && !data_acc[ch] && flag_q[ch]) |=> flag_q[ch]); // R4

      AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (fast_clr_en && data_acc[ch] && !set_vec[ch]) |=> !flag_q[ch]); // R5

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_vec[ch] && !(wr_now && !fast_clr_en && bus_wdata[ch])
          && !(fast_clr_en && data_acc[ch])) |=> $stable(flag_q[ch])); // R3

      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_en[ch] |-> !irq_ch[ch]); // R12
   end
endmodule

bind tmr_event_flags tmr_event_flags_chk #(
   .NUM_CH(NUM_CH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .fast_clr_en(fast_clr_en),
   .data_acc   (data_acc),
   .pacc16_evt (pacc16_evt),
   .irq_en     (irq_en),
   .irq_ch     (irq_ch),
   .irq        (irq),
   .set_vec    (set_vec),
   .flag_q     (flag_q)
);

// File: tb/test_tmr_event_flags.sv
module test_tmr_event_flags;
   localparam int NCH  = 8;
   localparam int NPA  = 4;
   localparam int DW   = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [NCH-1:0] bus_wdata = '0;
   logic [NCH-1:0] bus_rdata;
   logic           fast_clr_en = 1'b0;
   logic [NCH-1:0] data_acc = '0;
   logic [NCH-1:0] cc_evt = '0;
   logic           pacc16_evt = 1'b0;
   logic [NPA-1:0] pacc8_evt = '0;
   logic [DW-1:0]  dly_cycles = '0;
   logic           pair_mode = 1'b0;
   logic [NCH-1:0] ovw_prot = '0;
   logic [NCH-1:0] irq_en = '0;
   logic [NCH-1:0] irq_ch;
   logic           irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tmr_event_flags #(.NUM_CH(NCH), .NUM_PA8(NPA), .DLY_W(DW)) i_tmr_event_flags (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fast_clr_en(fast_clr_en),
      .data_acc(data_acc), .cc_evt(cc_evt), .pacc16_evt(pacc16_evt),
      .pacc8_evt(pacc8_evt), .dly_cycles(dly_cycles), .pair_mode(pair_mode),
      .ovw_prot(ovw_prot), .irq_en(irq_en), .irq_ch(irq_ch), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd_flags(output logic [NCH-1:0] v);
      bus_sel = 1'b1; bus_rd = 1'b1;
      #1 v = bus_rdata;
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic chk_flags(input string req, input logic [NCH-1:0] exp);
      logic [NCH-1:0] v;
      rd_flags(v);
      chk(req, 32'(v), 32'(exp));
   endtask

   task automatic wr(input logic [NCH-1:0] d);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse_cc(input logic [NCH-1:0] m);
      @(negedge clk); cc_evt = m;
      @(negedge clk); cc_evt = '0;
   endtask

   task automatic wait_flag(input int ch, output int k);
      logic [NCH-1:0] v;
      k = 0;
      rd_flags(v);
      while (!v[ch] && k < 300) begin
         @(negedge clk); k++;
         rd_flags(v);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NCH-1:0] v;
      int k;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_flags("R1 flags", '0);
      chk("R1 irq", 32'({irq_ch, irq}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: read data zero when not reading
      pulse_cc(8'h81);
      #1 chk("R2 no read", 32'(bus_rdata), 0);
      chk_flags("R2 read", 8'h81);
      wr(8'hFF);

      // R6 / R3 sweep over every channel
      for (int ch = 0; ch < NCH; ch++) begin
         pulse_cc(NCH'(1) << ch);
         chk_flags("R6 set", NCH'(1) << ch);
         wr(~(NCH'(1) << ch));
         chk_flags("R3 zero bits keep", NCH'(1) << ch);
         wr(NCH'(1) << ch);
         chk_flags("R3 clear", '0);
      end
      // R3 partial clear of a full register
      pulse_cc('1);
      wr(8'h5A);
      chk_flags("R3 partial", 8'hA5);
      // R5: access strobes ignored in normal mode
      @(negedge clk); data_acc = 8'hFF;
      @(negedge clk); data_acc = '0;
      chk_flags("R5 normal ignore", 8'hA5);
      wr('1);

      // R4 / R5 fast-clear mode
      fast_clr_en = 1'b1;
      pulse_cc('1);
      wr('1);
      chk_flags("R4 write ignored", 8'hFF);
      for (int ch = 0; ch < NCH; ch++) begin
         @(negedge clk); data_acc = NCH'(1) << ch;
         @(negedge clk); data_acc = '0;
         chk_flags("R5 access clear", 8'hFF << (ch + 1));
      end
      fast_clr_en = 1'b0;

      // R7 accumulator sources
      @(negedge clk); pacc16_evt = 1'b1;
      @(negedge clk); pacc16_evt = 1'b0;
      chk_flags("R7 wide acc", 8'h01);
      wr('1);
      for (int j = 0; j < NPA; j++) begin
         @(negedge clk); pacc8_evt = NPA'(1) << j;
         @(negedge clk); pacc8_evt = '0;
         chk_flags("R7 narrow acc", NCH'(1) << j);
         wr('1);
      end

      // R8 delay sweep
      for (int d = 1; d <= 6; d++) begin
         dly_cycles = DW'(d);
         pulse_cc(NCH'(1) << (d % NCH));
         wait_flag(d % NCH, k);
         chk("R8 delay", 32'(k), 32'(d));
         wr('1);
      end
      // R8 accumulator not delayed
      dly_cycles = DW'(4);
      @(negedge clk); pacc8_evt = 4'b0100;
      @(negedge clk); pacc8_evt = '0;
      chk_flags("R8 acc undelayed", 8'h04);
      wr('1);
      // R9 restart
      dly_cycles = DW'(6);
      pulse_cc(8'h10);
      repeat (3) @(negedge clk);
      pulse_cc(8'h10);
      wait_flag(4, k);
      chk("R9 restart", 32'(k), 32'd6);
      wr('1);
      dly_cycles = '0;

      // R10 pair mode
      pair_mode = 1'b1; ovw_prot = 8'h0F;
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
         pulse_cc(NCH'(1) << ch);
         chk_flags("R10 first", (ch >= 4) ? (NCH'(1) << ch) : '0);
         pulse_cc(NCH'(1) << ch);
         chk_flags("R10 second", NCH'(1) << ch);
         wr('1);
      end
      pair_mode = 1'b0; ovw_prot = '0;

      // R11 set wins over simultaneous clear
      pulse_cc(8'h24);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h24; cc_evt = 8'h04;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; cc_evt = '0;
      chk_flags("R11 set wins", 8'h04);
      fast_clr_en = 1'b1;
      @(negedge clk); data_acc = 8'h04; pacc16_evt = 1'b1; cc_evt = 8'h04;
      @(negedge clk); data_acc = '0; pacc16_evt = 1'b0; cc_evt = '0;
      chk_flags("R11 fast set wins", 8'h05);
      fast_clr_en = 1'b0;
      wr('1);

      // R12 interrupt masking
      pulse_cc(8'h96);
      for (int e = 0; e < 16; e++) begin
         irq_en = NCH'(e * 17);
         #1;
         chk("R12 irq_ch", 32'(irq_ch), 32'(8'h96 & NCH'(e * 17)));
         chk("R12 irq", 32'(irq), 32'((8'h96 & NCH'(e * 17)) != 0));
      end
      irq_en = '0;
      rd_flags(v);
      chk("R12 flags kept", 32'(v), 32'h96);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule